// File: doc/BRIEF.md
# TDM Highway Frame Aligner

This block keeps a frame position counter for a time-division system highway and locks it to an external sync pulse. The counter runs in system-clock units. Each data bit spans a power-of-two number of clocks, so the frame start (slot 0, bit 0) can be placed at a programmed distance after the sync pulse with sub-bit resolution, anywhere inside one frame. From the counter the block decodes the time-slot number, the bit number within the slot, the sub-bit count and an enable for the one channel phase chosen on a multi-phase highway. The same enable gates a highway data bit.

In marker mode the offset is no longer applied. A sync pulse loads position zero, and the block raises a marker for one data-bit time at a chosen bit position. The sync pulse can be sampled on either clock edge. The marker can be launched on either edge.

Top module: `hwy_frame_aligner`

## Requirements
- R1: After reset, the position is zero (tsCount, bitCount and subCount read 0). frameStart and marker stay low until the first sync pulse has been detected.
- R2: A sync rising edge present at the sampling edge that precedes clock edge k is detected after edge k. The position is reloaded at edge k+1. With offset 0, frameStart is high in the cycle after edge k+1.
- R3: offset is counted in system clocks. frameStart rises offset clocks later than it would with offset 0. An offset at or above the clocks per frame is taken modulo that length.
- R4: Without sync the position increments once per clock and wraps to 0 after FRAME_BITS << rateSel clocks. A sync at any position realigns the counter.
- R5: rateSel encodes the clocks per bit as 1 << rateSel (0:1, 1:2, 2:4, 3:8). subCount is the position modulo that ratio. The bit index is the position divided by the ratio; tsCount is the bit index divided by 8 and bitCount is the bit index modulo 8.
- R6: Outside marker mode, frameStart is high for exactly one clock per frame, at position 0.
- R7: The sync input is sampled on the falling clock edge when dataFall XOR syncOpp is 1, otherwise on the rising edge. A pulse present only around the unselected edge is not seen.
- R8: phaseEn is high when subCount equals phaseSel, provided phaseSel is below the ratio; otherwise it stays low. hwyOut equals hwyIn AND phaseEn.
- R9: With markerMode = 1, frameStart stays low and a sync loads position 0 whatever the offset.
- R10: In marker mode, once synchronised, the internal marker is high for exactly the ratio clocks in which the bit index equals markPos.
- R11: With dataFall = 0 the marker follows R10 directly after rising edges. With dataFall = 1 it is launched on the falling edge, half a clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Frame sync pulse |
| dataFall | input | 1 | Data/marker edge: 1 selects the falling edge |
| syncOpp | input | 1 | 1 samples sync on the edge opposite the data edge |
| markerMode | input | 1 | 1 selects marker mode |
| rateSel | input | 2 | log2 of clocks per data bit |
| offset | input | POS_W | Sync-to-frame-start distance in clocks |
| markPos | input | BIT_W | Bit position of the marker |
| phaseSel | input | 3 | Active channel phase |
| hwyIn | input | 1 | Highway data bit to gate |
| frameStart | output | 1 | Frame start strobe |
| tsCount | output | BIT_W-3 | Time-slot number |
| bitCount | output | 3 | Bit number within slot |
| subCount | output | 3 | Clock number within bit |
| phaseEn | output | 1 | Active-phase enable |
| hwyOut | output | 1 | hwyIn gated by phaseEn |
| marker | output | 1 | Frame marker |

## Verification
The bench builds the block with a 193-bit frame, so the wrap point is not a power of two. With ratio 8 that gives 1544 clocks per frame, and a short run can still cover several full frames at every ratio. The 11-bit offset field then holds values more than ten frames long at ratio 1, which exercises the modulo reduction. Half-clock sync pulses separate the two sampling edges, and the marker is compared against both launch edges.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
  localparam int RATE_W  = 2;
  localparam int PHASE_W = 3;
  localparam int SUB_W   = 3;

  typedef struct packed {
    logic syncHit;
    logic armed;
    logic useOffset;
  } alignStrb_t;
endpackage

// File: rtl/hfa_ctrl.sv
module hfa_ctrl
  import hfa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       dataFall,
  input  logic       syncOpp,
  input  logic       markerMode,
  input  logic       markRaw,
  output alignStrb_t strb,
  output logic       marker
);
  logic syncNeg, syncSmp, syncPrev, armedQ, markNeg;
  logic sampleOnFall, hit;

  assign sampleOnFall = dataFall ^ syncOpp;
  assign hit = syncSmp & ~syncPrev;

  // Falling-edge captures for sync and marker launch.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      syncNeg <= 1'b0;
      markNeg <= 1'b0;
    end else begin
      syncNeg <= syncIn;
      markNeg <= markRaw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSmp  <= 1'b0;
      syncPrev <= 1'b0;
      armedQ   <= 1'b0;
    end else begin
      syncSmp  <= sampleOnFall ? syncNeg : syncIn;
      syncPrev <= syncSmp;
      if (hit) armedQ <= 1'b1;
    end
  end

  always_comb begin
    strb.syncHit   = hit;
    strb.armed     = armedQ;
    strb.useOffset = ~markerMode;
  end

  assign marker = dataFall ? markNeg : markRaw;
endmodule

// File: rtl/hfa_dpath.sv
module hfa_dpath
  import hfa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = 12,
  parameter int BIT_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  alignStrb_t         strb,
  input  logic [RATE_W-1:0]  rateSel,
  input  logic [POS_W-1:0]   offset,
  input  logic [BIT_W-1:0]   markPos,
  input  logic [PHASE_W-1:0] phaseSel,
  input  logic               hwyIn,
  output logic [POS_W-1:0]   posQ,
  output logic               frameStart,
  output logic [BIT_W-4:0]   tsCount,
  output logic [2:0]         bitCount,
  output logic [SUB_W-1:0]   subCount,
  output logic               phaseEn,
  output logic               hwyOut,
  output logic               markRaw
);
  localparam int EXT_W = POS_W + 4;

  logic [POS_W-1:0] frameLen, offMod, startVal, subMask;
  logic [EXT_W-1:0] rem, lenExt;
  logic [BIT_W-1:0] bitIdx;
  logic [PHASE_W:0] phaseCount;

  assign frameLen = POS_W'(FRAME_BITS) << rateSel;

  // Offset modulo frame length by conditional subtraction of len*8..len*1.
  always_comb begin
    lenExt = EXT_W'(frameLen);
    rem    = EXT_W'(offset);
    for (int k = 3; k >= 0; k--) begin
      if (rem >= (lenExt << k)) rem = rem - (lenExt << k);
    end
    offMod = rem[POS_W-1:0];
  end

  always_comb begin
    if (!strb.useOffset || offMod == '0) startVal = '0;
    else startVal = frameLen - offMod;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) posQ <= '0;
    else if (strb.syncHit) posQ <= startVal;
    else if (posQ >= frameLen - POS_W'(1)) posQ <= '0;
    else posQ <= posQ + POS_W'(1);
  end

  assign subMask    = (POS_W'(1) << rateSel) - POS_W'(1);
  assign subCount   = SUB_W'(posQ & subMask);
  assign bitIdx     = BIT_W'(posQ >> rateSel);
  assign tsCount    = bitIdx[BIT_W-1:3];
  assign bitCount   = bitIdx[2:0];
  assign phaseCount = (PHASE_W+1)'(1) << rateSel;
  assign phaseEn    = ({1'b0, phaseSel} < phaseCount) && (subCount == phaseSel);
  assign hwyOut     = hwyIn & phaseEn;
  assign frameStart = strb.armed && strb.useOffset && (posQ == '0);
  assign markRaw    = strb.armed && !strb.useOffset && (bitIdx == markPos);
endmodule

// File: rtl/hwy_frame_aligner.sv
module hwy_frame_aligner
  import hfa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS * 8 + 1),
  parameter int BIT_W      = $clog2(FRAME_BITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncIn,
  input  logic               dataFall,
  input  logic               syncOpp,
  input  logic               markerMode,
  input  logic [1:0]         rateSel,
  input  logic [POS_W-1:0]   offset,
  input  logic [BIT_W-1:0]   markPos,
  input  logic [2:0]         phaseSel,
  input  logic               hwyIn,
  output logic               frameStart,
  output logic [BIT_W-4:0]   tsCount,
  output logic [2:0]         bitCount,
  output logic [2:0]         subCount,
  output logic               phaseEn,
  output logic               hwyOut,
  output logic               marker
);
  alignStrb_t       strb;
  logic             markRaw;
  logic [POS_W-1:0] posQ;

  hfa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .dataFall(dataFall),
    .syncOpp(syncOpp), .markerMode(markerMode), .markRaw(markRaw),
    .strb(strb), .marker(marker)
  );

  hfa_dpath #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .BIT_W(BIT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rateSel(rateSel), .offset(offset),
    .markPos(markPos), .phaseSel(phaseSel), .hwyIn(hwyIn), .posQ(posQ),
    .frameStart(frameStart), .tsCount(tsCount), .bitCount(bitCount),
    .subCount(subCount), .phaseEn(phaseEn), .hwyOut(hwyOut), .markRaw(markRaw)
  );
endmodule

// File: rtl/hfa_chk.sv
module hfa_chk #(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = 12
) (
  input logic               clk,
  input logic               rstN,
  input hfa_pkg::alignStrb_t strb,
  input logic [POS_W-1:0]   pos,
  input logic [1:0]         rateSel,
  input logic [2:0]         phaseSel,
  input logic               phaseEn,
  input logic               frameStart,
  input logic               marker,
  input logic               markerMode
);
  // R1
  quiet_until_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.armed |-> (!frameStart && !marker));

  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.syncHit && (32'(pos) >= (FRAME_BITS << rateSel) - 1)) |=> (pos == '0));

  // R6
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !strb.syncHit) |=> !frameStart);

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(phaseSel) >= (1 << rateSel)) |-> !phaseEn);

  // R9
  marker_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    markerMode |-> !frameStart);

  // R9
  marker_zero_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.syncHit && !strb.useOffset) |=> (pos == '0));
endmodule

bind hwy_frame_aligner hfa_chk #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .pos(posQ), .rateSel(rateSel),
  .phaseSel(phaseSel), .phaseEn(phaseEn), .frameStart(frameStart),
  .marker(marker), .markerMode(markerMode)
);

// File: tb/sim_hwy_frame_aligner.sv
`timescale 1ns/1ps
module sim_hwy_frame_aligner;
  localparam int FB  = 193;
  localparam int PW  = $clog2(FB * 8 + 1);
  localparam int BWd = $clog2(FB);

  logic clk = 1'b0, rstN = 1'b0;
  logic syncIn = 0, dataFall = 0, syncOpp = 0, markerMode = 0, hwyIn = 0;
  logic [1:0] rateSel = 0;
  logic [PW-1:0] offset = 0;
  logic [BWd-1:0] markPos = 0;
  logic [2:0] phaseSel = 0;
  logic frameStart, phaseEn, hwyOut, marker;
  logic [BWd-4:0] tsCount;
  logic [2:0] bitCount, subCount;

  int checks = 0, fails = 0;
  string tag = "R1";
  int mSmp = 0, mPrev = 0, mPos = 0, mArmed = 0, mNegSync = 0, mNegMark = 0;

  always #10 clk = ~clk;

  hwy_frame_aligner #(.FRAME_BITS(FB)) u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .dataFall(dataFall), .syncOpp(syncOpp),
    .markerMode(markerMode), .rateSel(rateSel), .offset(offset), .markPos(markPos),
    .phaseSel(phaseSel), .hwyIn(hwyIn), .frameStart(frameStart), .tsCount(tsCount),
    .bitCount(bitCount), .subCount(subCount), .phaseEn(phaseEn), .hwyOut(hwyOut),
    .marker(marker)
  );

  function automatic int bitIndex();
    return (mPos / (1 << rateSel)) % (1 << BWd);
  endfunction

  // Reference view of the falling edge: sync capture and marker launch.
  always @(negedge clk) begin
    if (!rstN) begin
      mNegSync = 0; mNegMark = 0;
    end else begin
      mNegSync = syncIn;
      mNegMark = (mArmed != 0 && markerMode && bitIndex() == markPos) ? 1 : 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    int len, om, start, hit;
    len = FB << rateSel;
    om = offset % len;
    start = (markerMode || om == 0) ? 0 : len - om;
    hit = (mSmp != 0 && mPrev == 0) ? 1 : 0;
    if (hit != 0) begin mPos = start; mArmed = 1; end
    else if (mPos >= len - 1) mPos = 0;
    else mPos = mPos + 1;
    mPrev = mSmp;
    mSmp = ((dataFall ^ syncOpp) != 0) ? mNegSync : int'(syncIn);
  endtask

  task automatic compareAll();
    int r, bi, pe, mr;
    r = 1 << rateSel;
    bi = bitIndex();
    pe = (phaseSel < r && (mPos % r) == phaseSel) ? 1 : 0;
    mr = (mArmed != 0 && markerMode && bi == markPos) ? 1 : 0;
    check("R5 tsCount", int'(tsCount), bi / 8);
    check("R5 bitCount", int'(bitCount), bi % 8);
    check("R5 subCount", int'(subCount), mPos % r);
    check("R2 frameStart", int'(frameStart), (mArmed != 0 && !markerMode && mPos == 0) ? 1 : 0);
    check("R8 phaseEn", int'(phaseEn), pe);
    check("R8 hwyOut", int'(hwyOut), int'(hwyIn) & pe);
    check("R10 marker", int'(marker), dataFall ? mNegMark : mr);
  endtask

  // kind: 0 no sync, 1 full-cycle pulse, 2 pulse only across the falling edge
  task automatic step(int kind);
    @(posedge clk);
    modelEdge();
    #5;
    compareAll();
    hwyIn = ~hwyIn;
    syncIn = (kind != 0);
    if (kind == 2) begin #10; syncIn = 0; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #35;
    // R1 reset state
    check("R1 tsCount", int'(tsCount), 0);
    check("R1 bitCount", int'(bitCount), 0);
    check("R1 frameStart", int'(frameStart), 0);
    check("R1 marker", int'(marker), 0);
    rstN = 1;
    tag = "R1"; run(300);                      // free run, no strobes yet
    tag = "R4"; run(10);
    tag = "R2"; step(1); run(400);             // offset 0
    tag = "R3"; offset = 5; step(1); run(400);
    tag = "R6"; rateSel = 3; offset = 1000; step(1); run(3200);
    tag = "R3"; rateSel = 0; offset = 2000; step(1); run(450);  // modulo
    tag = "R4"; step(1); run(50); step(1); run(300);           // realign
    tag = "R7"; offset = 7; syncOpp = 1; step(2); run(300);    // falling sample
    tag = "R7"; offset = 30; syncOpp = 0; step(2); run(300);   // missed
    tag = "R7"; dataFall = 1; syncOpp = 1; step(2); run(300);  // missed
    tag = "R7"; dataFall = 1; syncOpp = 0; step(2); run(300);  // seen
    dataFall = 0;
    tag = "R8"; rateSel = 2; phaseSel = 2; step(1); run(900);
    tag = "R8"; phaseSel = 5; run(200);
    tag = "R8"; rateSel = 3; run(200);
    tag = "R9"; markerMode = 1; rateSel = 1; markPos = 10; offset = 77; step(1); run(900);
    tag = "R10"; markPos = 192; run(900);
    tag = "R11"; dataFall = 1; markPos = 3; step(1); run(900);
    tag = "R11"; rateSel = 0; markPos = 0; step(1); run(450);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule